// File: doc/BRIEF.md
# Multi-channel doorbell mailbox

This block carries events one way, from a sender register port to a receiver register port. It has a configurable number of doorbell channels, and each channel holds 32 independent one-bit event flags. The sender raises flags with write-1-to-set writes, and one write may raise several flags at once. The receiver reads the pending flags and clears the ones it has handled with write-1-to-clear writes. A registered interrupt to the receiver stays high while any pending flag is enabled in the receiver's mask.

Clearing a flag also acknowledges it. For every flag bit that the sender has enabled in its acknowledgment mask, a 1-to-0 transition of that flag latches a per-channel acknowledgment bit. The sender reads these bits, clears them with write-1-to-clear, and can use a registered completion interrupt. Both sides can read a capability word that reports the number of channels. Two-way signalling needs two instances of the block.

Address layout on both ports: `addr[8:7]` selects a page and `addr[6:0]` selects a channel index. On page 3, index 0 is the side's mask word and index 1 is the capability word.

Top module: `dbmb_top`

## Requirements
- R1: After reset, all flags, acknowledgment bits and mask words are zero, and both interrupt outputs are low.
- R2: A sender write to page 0 of channel c sets each flag of c whose data bit is 1. Data bits of 0 leave their flags unchanged, and a flag that is already set stays set.
- R3: A receiver write to page 1 of channel c clears each flag of c whose data bit is 1. Other flags are unchanged.
- R4: When a set and a clear hit the same flag in the same cycle, the flag is set afterwards.
- R5: A read of sender page 0 or 1, or of receiver page 0 or 1, returns the flags of the addressed channel. A read of receiver page 2 returns zero, and writes to that page change nothing.
- R6: `r_irq` goes high one cycle after any channel has a flag that is set and enabled in the receiver mask. It stays high while that condition holds and falls one cycle after it ends.
- R7: When a flag goes from 1 to 0 and its bit is set in the sender acknowledgment mask, bit f of channel c's acknowledgment word is set. The sender reads this word on page 2. A flag that falls while its mask bit is 0 latches nothing.
- R8: A sender write to page 2 clears the acknowledgment bits whose data bits are 1. If a new acknowledgment arrives for the same bit in the same cycle, the bit stays set.
- R9: `s_ack_irq` goes high one cycle after any acknowledgment bit is set, and falls one cycle after none is set.
- R10: Page 3 index 0 is the receiver interrupt mask on the receiver port and the acknowledgment mask on the sender port. Both are read/write. Page 3 index 1 reads NUM_CH on both ports and ignores writes. Other page 3 indices read zero.
- R11: A channel index at or above NUM_CH reads zero on every page and ignores writes.
- R12: A write to one channel changes no other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_we | input | 1 | Sender write strobe |
| s_addr | input | 9 | Sender address: page in [8:7], channel in [6:0] |
| s_wdata | input | 32 | Sender write data |
| s_rdata | output | 32 | Sender read data (combinational from s_addr) |
| r_we | input | 1 | Receiver write strobe |
| r_addr | input | 9 | Receiver address: page in [8:7], channel in [6:0] |
| r_wdata | input | 32 | Receiver write data |
| r_rdata | output | 32 | Receiver read data (combinational from r_addr) |
| r_irq | output | 1 | Receiver interrupt, registered |
| s_ack_irq | output | 1 | Sender acknowledgment interrupt, registered |

## Verification
The assertions check the following on every cycle:
- a flag rises only where a set was issued, and falls only where a clear was issued;
- an issued set always lands, even against a simultaneous clear;
- an acknowledgment bit appears only on an enabled falling flag;
- both interrupts follow their conditions with one register of delay;
- the capability word reads the channel count.

Some behaviours only the bench's scenarios can show:
- that writes of zero leave flags alone;
- that accesses to a channel index at or above NUM_CH really change no channel;
- that the mask words read back correctly;
- that the acknowledgment clear loses to a same-cycle new acknowledgment.

The bench shows these by comparing every read port against a behavioural model.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;
  localparam int FLAG_W = 32;
  localparam int CH_AW  = 7;
  localparam int ADDR_W = CH_AW + 2;

  typedef logic [FLAG_W-1:0] flag_word_t;

  // page numbers, shared by both ports
  localparam logic [1:0] PG_0    = 2'd0;
  localparam logic [1:0] PG_1    = 2'd1;
  localparam logic [1:0] PG_2    = 2'd2;
  localparam logic [1:0] PG_CTRL = 2'd3;
  localparam logic [CH_AW-1:0] IDX_MASK = 7'd0;
  localparam logic [CH_AW-1:0] IDX_CAP  = 7'd1;

  function automatic logic [1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: 2];
  endfunction

  function automatic logic [CH_AW-1:0] chan_of(input logic [ADDR_W-1:0] a);
    return a[CH_AW-1:0];
  endfunction

  // set has priority over clear
  function automatic flag_word_t flags_next(input flag_word_t cur,
                                            input flag_word_t set_v,
                                            input flag_word_t clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  function automatic flag_word_t fall_edges(input flag_word_t cur,
                                            input flag_word_t nxt,
                                            input flag_word_t en);
    return cur & ~nxt & en;
  endfunction

  // a fresh acknowledgment has priority over its clear
  function automatic flag_word_t ack_next(input flag_word_t cur,
                                          input flag_word_t wipe,
                                          input flag_word_t fresh);
    return (cur & ~wipe) | fresh;
  endfunction
endpackage

// File: rtl/dbmb_chan.sv
module dbmb_chan
  import dbmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  flag_word_t raise,
  input  flag_word_t lower,
  input  flag_word_t ack_en,
  input  flag_word_t ack_wipe,
  output flag_word_t flags,
  output flag_word_t ack_pend,
  output flag_word_t fell
);
  flag_word_t nxt;

  assign nxt  = flags_next(flags, raise, lower);
  assign fell = fall_edges(flags, nxt, ack_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags    <= '0;
      ack_pend <= '0;
    end else begin
      flags    <= nxt;
      ack_pend <= ack_next(ack_pend, ack_wipe, fell);
    end
  end
endmodule

// File: rtl/dbmb_sport.sv
module dbmb_sport
  import dbmb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  flag_word_t                     wdata,
  input  logic [NUM_CH-1:0][FLAG_W-1:0]  flags,
  input  logic [NUM_CH-1:0][FLAG_W-1:0]  ack_pend,
  output logic [NUM_CH-1:0][FLAG_W-1:0]  raise,
  output logic [NUM_CH-1:0][FLAG_W-1:0]  ack_wipe,
  output flag_word_t                     ack_en,
  output flag_word_t                     rdata,
  output logic                           ack_irq
);
  logic [1:0]       pg;
  logic [CH_AW-1:0] ch;

  assign pg = page_of(addr);
  assign ch = chan_of(addr);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    logic hit;
    assign hit         = we && (ch == CH_AW'(i));
    assign raise[i]    = (hit && pg == PG_0) ? wdata : '0;
    assign ack_wipe[i] = (hit && pg == PG_2) ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_en  <= '0;
      ack_irq <= 1'b0;
    end else begin
      if (we && pg == PG_CTRL && ch == IDX_MASK) ack_en <= wdata;
      ack_irq <= |ack_pend;
    end
  end

  always_comb begin
    rdata = '0;
    if (pg == PG_CTRL) begin
      if (ch == IDX_MASK)     rdata = ack_en;
      else if (ch == IDX_CAP) rdata = FLAG_W'(NUM_CH);
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch == CH_AW'(i)) begin
          if (pg == PG_2) rdata = ack_pend[i];
          else            rdata = flags[i];
        end
      end
    end
  end
endmodule

// File: rtl/dbmb_rport.sv
module dbmb_rport
  import dbmb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  flag_word_t                     wdata,
  input  logic [NUM_CH-1:0][FLAG_W-1:0]  flags,
  output logic [NUM_CH-1:0][FLAG_W-1:0]  lower,
  output flag_word_t                     irq_mask,
  output flag_word_t                     rdata,
  output logic                           irq
);
  logic [1:0]       pg;
  logic [CH_AW-1:0] ch;
  logic             masked_any;

  assign pg = page_of(addr);
  assign ch = chan_of(addr);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign lower[i] = (we && pg == PG_1 && ch == CH_AW'(i)) ? wdata : '0;
  end

  always_comb begin
    masked_any = 1'b0;
    for (int i = 0; i < NUM_CH; i++) masked_any = masked_any | (|(flags[i] & irq_mask));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_mask <= '0;
      irq      <= 1'b0;
    end else begin
      if (we && pg == PG_CTRL && ch == IDX_MASK) irq_mask <= wdata;
      irq <= masked_any;
    end
  end

  always_comb begin
    rdata = '0;
    if (pg == PG_CTRL) begin
      if (ch == IDX_MASK)     rdata = irq_mask;
      else if (ch == IDX_CAP) rdata = FLAG_W'(NUM_CH);
    end else if (pg != PG_2) begin
      for (int i = 0; i < NUM_CH; i++)
        if (ch == CH_AW'(i)) rdata = flags[i];
    end
  end
endmodule

// File: rtl/dbmb_top.sv
module dbmb_top
  import dbmb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_we,
  input  logic [8:0]  s_addr,
  input  logic [31:0] s_wdata,
  output logic [31:0] s_rdata,
  input  logic        r_we,
  input  logic [8:0]  r_addr,
  input  logic [31:0] r_wdata,
  output logic [31:0] r_rdata,
  output logic        r_irq,
  output logic        s_ack_irq
);
  // named internal events, observed by the bound checker
  logic [NUM_CH-1:0][FLAG_W-1:0] raise_all;
  logic [NUM_CH-1:0][FLAG_W-1:0] lower_all;
  logic [NUM_CH-1:0][FLAG_W-1:0] wipe_all;
  logic [NUM_CH-1:0][FLAG_W-1:0] flags_all;
  logic [NUM_CH-1:0][FLAG_W-1:0] ack_all;
  logic [NUM_CH-1:0][FLAG_W-1:0] fell_all;
  flag_word_t                    ack_en;
  flag_word_t                    irq_mask;

  dbmb_sport #(.NUM_CH(NUM_CH)) u_sport (
    .clk(clk), .rst_n(rst_n), .we(s_we), .addr(s_addr), .wdata(s_wdata),
    .flags(flags_all), .ack_pend(ack_all), .raise(raise_all),
    .ack_wipe(wipe_all), .ack_en(ack_en), .rdata(s_rdata), .ack_irq(s_ack_irq)
  );

  dbmb_rport #(.NUM_CH(NUM_CH)) u_rport (
    .clk(clk), .rst_n(rst_n), .we(r_we), .addr(r_addr), .wdata(r_wdata),
    .flags(flags_all), .lower(lower_all), .irq_mask(irq_mask),
    .rdata(r_rdata), .irq(r_irq)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dbmb_chan u_chan (
      .clk(clk), .rst_n(rst_n), .raise(raise_all[i]), .lower(lower_all[i]),
      .ack_en(ack_en), .ack_wipe(wipe_all[i]), .flags(flags_all[i]),
      .ack_pend(ack_all[i]), .fell(fell_all[i])
    );
  end
endmodule

// File: rtl/dbmb_chk.sv
module dbmb_chk
  import dbmb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CH-1:0][FLAG_W-1:0] raise_all,
  input logic [NUM_CH-1:0][FLAG_W-1:0] lower_all,
  input logic [NUM_CH-1:0][FLAG_W-1:0] flags_all,
  input logic [NUM_CH-1:0][FLAG_W-1:0] ack_all,
  input flag_word_t                    ack_en,
  input flag_word_t                    irq_mask,
  input logic                          r_irq,
  input logic                          s_ack_irq,
  input logic [8:0]                    s_addr,
  input logic [31:0]                   s_rdata,
  input logic [8:0]                    r_addr,
  input logic [31:0]                   r_rdata
);
  logic [NUM_CH-1:0][FLAG_W-1:0] en_rep;
  logic                          masked_hit;

  always_comb begin
    masked_hit = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      en_rep[i]  = ack_en;
      masked_hit = masked_hit || ((flags_all[i] & irq_mask) != '0);
    end
  end

  // R2
  rise_only_by_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_all & ~$past(flags_all) & ~$past(raise_all)) == '0));
  // R3
  fall_only_by_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags_all) & ~flags_all & ~$past(lower_all)) == '0));
  // R4
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise_all) |=> ((flags_all & $past(raise_all)) == $past(raise_all)));
  // R6
  rx_irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (r_irq == $past(masked_hit)));
  // R7
  ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ack_all & ~$past(ack_all)
               & ~($past(flags_all) & ~flags_all & $past(en_rep))) == '0));
  // R9
  ack_irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (s_ack_irq == $past(ack_all != '0)));
  // R10
  s_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_addr == {PG_CTRL, IDX_CAP}) |-> (s_rdata == 32'(NUM_CH)));
  // R10
  r_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_addr == {PG_CTRL, IDX_CAP}) |-> (r_rdata == 32'(NUM_CH)));
endmodule

bind dbmb_top dbmb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .raise_all(raise_all), .lower_all(lower_all),
  .flags_all(flags_all), .ack_all(ack_all), .ack_en(ack_en),
  .irq_mask(irq_mask), .r_irq(r_irq), .s_ack_irq(s_ack_irq),
  .s_addr(s_addr), .s_rdata(s_rdata), .r_addr(r_addr), .r_rdata(r_rdata)
);

// File: tb/test_dbmb_top.sv
module test_dbmb_top;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_we = 1'b0, r_we = 1'b0;
  logic [8:0]  s_addr = '0, r_addr = '0;
  logic [31:0] s_wdata = '0, r_wdata = '0;
  logic [31:0] s_rdata, r_rdata;
  logic        r_irq, s_ack_irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] mf [N];
  logic [31:0] ma [N];
  logic [31:0] m_ack_en, m_rmask;
  logic        m_rirq, m_airq;

  always #10 clk = ~clk;

  dbmb_top #(.NUM_CH(N)) i_dbmb_top (
    .clk(clk), .rst_n(rst_n), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_irq(r_irq), .s_ack_irq(s_ack_irq)
  );

  function automatic logic [8:0] ad(input int pg, input int ch);
    return {pg[1:0], ch[6:0]};
  endfunction

  function automatic logic [31:0] m_sread(input logic [8:0] a);
    int pg = int'(a[8:7]);
    int ch = int'(a[6:0]);
    if (pg == 3) return (ch == 0) ? m_ack_en : (ch == 1) ? 32'(N) : 32'h0;
    if (ch >= N) return 32'h0;
    return (pg == 2) ? ma[ch] : mf[ch];
  endfunction

  function automatic logic [31:0] m_rread(input logic [8:0] a);
    int pg = int'(a[8:7]);
    int ch = int'(a[6:0]);
    if (pg == 3) return (ch == 0) ? m_rmask : (ch == 1) ? 32'(N) : 32'h0;
    if (ch >= N || pg == 2) return 32'h0;
    return mf[ch];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin mf[i] = '0; ma[i] = '0; end
    m_ack_en = '0; m_rmask = '0; m_rirq = 0; m_airq = 0;
  endtask

  task automatic model_step();
    logic [31:0] nf [N];
    logic        any_m = 0, any_a = 0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] setv = 0, clrv = 0, wipe = 0;
      any_m = any_m | ((mf[i] & m_rmask) != 0);
      any_a = any_a | (ma[i] != 0);
      if (s_we && s_addr == ad(0, i)) setv = s_wdata;
      if (s_we && s_addr == ad(2, i)) wipe = s_wdata;
      if (r_we && r_addr == ad(1, i)) clrv = r_wdata;
      nf[i] = (mf[i] & ~clrv) | setv;
      ma[i] = (ma[i] & ~wipe) | (mf[i] & ~nf[i] & m_ack_en);
      mf[i] = nf[i];
    end
    if (s_we && s_addr == ad(3, 0)) m_ack_en = s_wdata;
    if (r_we && r_addr == ad(3, 0)) m_rmask = r_wdata;
    m_rirq = any_m;
    m_airq = any_a;
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic op(input logic sw, input logic [8:0] sa, input logic [31:0] sd,
                    input logic rw, input logic [8:0] ra, input logic [31:0] rd,
                    input string tag);
    s_we = sw; s_addr = sa; s_wdata = sd;
    r_we = rw; r_addr = ra; r_wdata = rd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    s_we = 0; r_we = 0;
    chk(tag, "s_rdata", s_rdata, m_sread(s_addr));
    chk(tag, "r_rdata", r_rdata, m_rread(r_addr));
    chk(tag, "r_irq", {31'b0, r_irq}, {31'b0, m_rirq});
    chk(tag, "s_ack_irq", {31'b0, s_ack_irq}, {31'b0, m_airq});
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state on every readable word
    op(0, ad(0, 0), 0, 0, ad(0, 0), 0, "R1");
    op(0, ad(2, 3), 0, 0, ad(3, 0), 0, "R1");
    op(0, ad(3, 0), 0, 0, ad(1, 2), 0, "R1");
    // R10: capability on both sides, write to it ignored
    op(1, ad(3, 1), 32'hFFFF, 1, ad(3, 1), 32'h1234, "R10");
    op(0, ad(3, 5), 0, 0, ad(3, 9), 0, "R10");
    // R2: raise, zero write, re-raise
    op(1, ad(0, 0), 32'h5, 0, ad(0, 0), 0, "R2");
    op(1, ad(0, 0), 32'h0, 0, ad(1, 0), 0, "R2");
    op(1, ad(0, 0), 32'h4, 0, ad(0, 0), 0, "R2");
    // R12: several flags in another channel, channel 0 unchanged
    op(1, ad(0, 2), 32'hF0F0_0001, 0, ad(0, 0), 0, "R12");
    op(0, ad(1, 2), 0, 0, ad(0, 1), 0, "R12");
    // R5: receiver page 2 reads zero, writes ignored
    op(0, ad(1, 0), 0, 1, ad(2, 0), 32'hFFFF_FFFF, "R5");
    op(0, ad(0, 0), 0, 0, ad(0, 0), 0, "R5");
    // R6 and R10: mask on, irq follows one cycle later, then off
    op(0, ad(0, 0), 0, 1, ad(3, 0), 32'h1, "R6");
    op(0, ad(0, 0), 0, 0, ad(3, 0), 0, "R6");
    op(0, ad(0, 0), 0, 1, ad(3, 0), 32'h0, "R6");
    op(0, ad(0, 0), 0, 0, ad(0, 0), 0, "R6");
    // R7: enable ack on bit 0, clear bits 0 and 2
    op(1, ad(3, 0), 32'h1, 0, ad(0, 0), 0, "R7");
    op(0, ad(2, 0), 0, 1, ad(1, 0), 32'h5, "R7");
    op(0, ad(2, 0), 0, 0, ad(0, 0), 0, "R9");
    // R4: set and clear on the same flag in the same cycle
    op(1, ad(0, 1), 32'h8, 1, ad(1, 1), 32'h8, "R4");
    op(0, ad(0, 1), 0, 0, ad(0, 1), 0, "R4");
    // R8: fresh ack and wipe on the same bit in the same cycle
    op(1, ad(0, 0), 32'h1, 0, ad(0, 0), 0, "R8");
    op(1, ad(2, 0), 32'h1, 1, ad(1, 0), 32'h1, "R8");
    op(1, ad(2, 0), 32'h1, 0, ad(0, 0), 0, "R8");
    op(0, ad(2, 0), 0, 0, ad(0, 0), 0, "R9");
    // R11: out-of-range channels
    op(1, ad(0, N), 32'hFFFF_FFFF, 1, ad(1, N), 32'hFFFF_FFFF, "R11");
    op(1, ad(2, 127), 32'hFFFF_FFFF, 0, ad(0, 127), 0, "R11");
    op(0, ad(0, N), 0, 0, ad(0, N), 0, "R11");
    // random mix (R12)
    for (int k = 0; k < 400; k++) begin
      int sp = $urandom_range(0, 3);
      int rp = $urandom_range(0, 3);
      int sc = (sp == 3) ? $urandom_range(0, 2) : $urandom_range(0, N + 1);
      int rc = (rp == 3) ? $urandom_range(0, 2) : $urandom_range(0, N + 1);
      op(1'($urandom_range(0, 1)), ad(sp, sc), $urandom & $urandom,
         1'($urandom_range(0, 1)), ad(rp, rc), $urandom | $urandom, "R12");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule